// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block holds the control and status logic that sits behind an on-chip analog comparator. The asynchronous comparator output is first brought into the clock domain. Transitions on the synchronized level are then watched according to a two-bit event mode. A matching transition sets a sticky pending flag, which raises an interrupt request when the local enable and the global enable input are both high. The flag clears in two ways: when the interrupt controller acknowledges the vector, or when software writes a one to the flag bit. Optionally, the synchronized comparator level is routed straight to a timer's input-capture trigger.

Software reaches the block through a byte-wide bus with write and read strobes and a two-bit address. Address 0 is the control/status byte, address 1 is a digital-input-disable byte for two pins, and address 2 is the read-only pin readback. Read data is registered: it appears in the cycle after the read strobe and holds until the next read.

The block has two small state machines. The edge watcher has the states `EDGE_WARM` and `EDGE_RUN`, with one transition: WARM goes to RUN after `SYNC_STAGES+1` clocks from reset. The pending flag has the states `FLAG_IDLE` and `FLAG_PEND`, with these transitions:
- IDLE to PEND on an event.
- PEND to IDLE on an acknowledge or a software clear, provided no event arrives in the same cycle.
- PEND stays in PEND when an event and a clear arrive in the same cycle.

Top module: `acmp_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, except control bit 5, which shows the synchronized comparator level. `irq` and `cap_trig` are low.
- R2: Mode 2'b11, held in control bits [1:0], sets the flag (control bit 4) on a rising comparator edge only.
- R3: Mode 2'b10 sets the flag on a falling comparator edge only.
- R4: Mode 2'b00 sets the flag on either comparator edge.
- R5: Mode 2'b01 is reserved, and in this mode no comparator transition sets the flag.
- R6: A one-cycle `irq_ack` pulse clears the flag. Writing control bit 4 as one clears the flag, and writing it as zero leaves the flag unchanged.
- R7: When an event and a clear (acknowledge or write-one) fall in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when the flag, the enable bit (control bit 3) and the `gie` input are all high.
- R9: When control bit 2 is one, `cap_trig` follows the synchronized comparator level. When bit 2 is zero, `cap_trig` is held low.
- R10: Changing the mode while the comparator is steady can itself register as an event. For example, going from 2'b11 to 2'b10 with the comparator low sets the flag, and with the enable bit set it raises `irq`.
- R11: In the byte at address 1, bits [1:0] are read/write and bits [7:2] always read zero. A set bit forces the matching pin bit at address 2 to read zero.
- R12: The comparator passes through a two-flop synchronizer. A level that is held high through reset release produces no event.
- R13: `bus_rdata` loads the selected register one clock after `bus_rd` is sampled and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | 1 | Asynchronous comparator output |
| pin_raw | input | PIN_W | Asynchronous digital pin inputs |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Vector acknowledge pulse, clears the flag |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address (0 control, 1 input disable, 2 pin readback) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| cap_trig | output | 1 | Input-capture trigger to the timer |

## Verification
The assertions check the following on every cycle:
- The flag machine lets a same-cycle event win over a clear, and it drops to idle on a clear when no event is present.
- The reserved mode never sets an idle flag.
- Reserved bits of the disable byte always read zero.
- Read data holds its value without a read strobe.

Only the bench scenarios can show the edge selection of each mode, the spurious event caused by a mode change, the quiet start with the comparator held high through reset, and the gating of the request and the capture trigger. The bench shows these by comparing against its behavioural model on every clock and by reading the registers back.

// File: rtl/acmp_pkg.sv
package acmp_pkg;

    typedef enum logic [1:0] {
        MODE_TOGGLE = 2'b00,
        MODE_RSVD   = 2'b01,
        MODE_FALL   = 2'b10,
        MODE_RISE   = 2'b11
    } acmp_mode_e;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_e;

    typedef enum logic {
        EDGE_WARM = 1'b0,
        EDGE_RUN  = 1'b1
    } edge_state_e;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_DIS  = 1;
    localparam int ADDR_PIN  = 2;

    localparam int BIT_CAP  = 2;
    localparam int BIT_IE   = 3;
    localparam int BIT_FLAG = 4;
    localparam int BIT_LVL  = 5;

endpackage

// File: rtl/acmp_sync.sv
module acmp_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
        end else begin
            pipe_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/acmp_edge_det.sv
module acmp_edge_det
    import acmp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    input  acmp_mode_e mode_i,
    output logic       evt_o
);
    localparam int WARM_CYC = SYNC_STAGES + 1;
    localparam int CNT_W    = $clog2(WARM_CYC + 1);

    edge_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             watch;
    logic             prev_q;

    // The watched signal is inverted in falling mode, so that mode
    // changes can move it and create an event.
    assign watch = (mode_i == MODE_FALL) ? ~lvl_i : lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EDGE_WARM;
            cnt_q   <= '0;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= watch;
            if (state_q == EDGE_WARM) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_WARM: if (cnt_q == CNT_W'(WARM_CYC - 1)) state_d = EDGE_RUN;
            EDGE_RUN:  state_d = EDGE_RUN;
            default:   state_d = EDGE_WARM;
        endcase
    end

    always_comb begin
        evt_o = 1'b0;
        if (state_q == EDGE_RUN) begin
            unique case (mode_i)
                MODE_TOGGLE: evt_o = watch ^ prev_q;
                MODE_RSVD:   evt_o = 1'b0;
                MODE_FALL,
                MODE_RISE:   evt_o = watch & ~prev_q;
                default:     evt_o = 1'b0;
            endcase
        end
    end

    // R12: after warm-up the watched level is always tracked
    a_r12_prev_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EDGE_RUN) |=> (prev_q == $past(watch)));
endmodule

// File: rtl/acmp_flag_fsm.sv
module acmp_flag_fsm
    import acmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (set_i) state_d = FLAG_PEND;
            FLAG_PEND: if (clr_i && !set_i) state_d = FLAG_IDLE;
            default:   state_d = FLAG_IDLE;
        endcase
    end

    always_comb flag_o = (state_q == FLAG_PEND);

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/acmp_irq_ctrl.sv
module acmp_irq_ctrl
    import acmp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PIN_W       = 2,
    parameter int ADDR_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_raw,
    input  logic [PIN_W-1:0]  pin_raw,
    input  logic              gie,
    input  logic              irq_ack,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              cap_trig
);
    localparam int PAD_W = 8 - PIN_W;

    logic             cmp_s;
    logic [PIN_W-1:0] pin_s;
    acmp_mode_e       mode_q;
    logic             cap_q, ie_q;
    logic [PIN_W-1:0] dis_q;
    logic             evt, flag, sw_clr;
    logic             wr_ctrl, wr_dis;
    logic [7:0]       rd_mux;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata[7:6];

    acmp_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_cmp_sync (
        .clk(clk), .rst_n(rst_n), .d_i(cmp_raw), .q_o(cmp_s));

    acmp_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_raw), .q_o(pin_s));

    acmp_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(cmp_s), .mode_i(mode_q), .evt_o(evt));

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
    assign wr_dis  = bus_wr && (bus_addr == ADDR_W'(ADDR_DIS));
    assign sw_clr  = wr_ctrl && bus_wdata[BIT_FLAG];

    acmp_flag_fsm u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(evt), .clr_i(irq_ack || sw_clr), .flag_o(flag));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_TOGGLE;
            cap_q  <= 1'b0;
            ie_q   <= 1'b0;
            dis_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                mode_q <= acmp_mode_e'(bus_wdata[1:0]);
                cap_q  <= bus_wdata[BIT_CAP];
                ie_q   <= bus_wdata[BIT_IE];
            end
            if (wr_dis) dis_q <= bus_wdata[PIN_W-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
            rd_mux[1:0]      = mode_q;
            rd_mux[BIT_CAP]  = cap_q;
            rd_mux[BIT_IE]   = ie_q;
            rd_mux[BIT_FLAG] = flag;
            rd_mux[BIT_LVL]  = cmp_s;
        end else if (bus_addr == ADDR_W'(ADDR_DIS)) begin
            rd_mux = {{PAD_W{1'b0}}, dis_q};
        end else if (bus_addr == ADDR_W'(ADDR_PIN)) begin
            rd_mux = {{PAD_W{1'b0}}, pin_s & ~dis_q};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign irq      = flag && ie_q && gie;
    assign cap_trig = cap_q && cmp_s;

    a_r11_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(ADDR_DIS)) |=> (bus_rdata[7:PIN_W] == '0));

    a_r13_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    a_r5_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RSVD && !flag) |=> !flag);

    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gie && ie_q));
endmodule

// File: tb/acmp_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module acmp_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_raw = 1'b1;
    logic [1:0] pin_raw = 2'b00;
    logic       gie = 1'b0, irq_ack = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, cap_trig;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    acmp_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .pin_raw(pin_raw), .gie(gie),
        .irq_ack(irq_ack), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .cap_trig(cap_trig));

    // Behavioural reference model
    logic [1:0] m_c, m_p1, m_p2;
    logic       m_seen;
    int         m_age;
    logic [1:0] m_mode, m_dis;
    logic       m_cap, m_ie, m_flag;
    logic [7:0] m_rd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_c = 2'b00; m_p1 = 2'b00; m_p2 = 2'b00; m_seen = 1'b0; m_age = 0;
            m_mode = 2'b00; m_dis = 2'b00; m_cap = 1'b0; m_ie = 1'b0;
            m_flag = 1'b0; m_rd = 8'h00;
        end else begin
            logic lvl, obs, hit, clr;
            logic [7:0] nrd;
            lvl = m_c[1];
            obs = (m_mode == 2'b10) ? !lvl : lvl;
            hit = 1'b0;
            if (m_age >= 3) begin
                if (m_mode == 2'b00) hit = (obs != m_seen);
                else if (m_mode != 2'b01) hit = obs && !m_seen;
            end
            clr = irq_ack || (bus_wr && bus_addr == 2'd0 && bus_wdata[4]);
            nrd = m_rd;
            if (bus_rd) begin
                case (bus_addr)
                    2'd0: nrd = {2'b00, lvl, m_flag, m_ie, m_cap, m_mode};
                    2'd1: nrd = {6'd0, m_dis};
                    2'd2: nrd = {6'd0, m_p2 & ~m_dis};
                    default: nrd = 8'h00;
                endcase
            end
            m_rd = nrd;
            if (hit) m_flag = 1'b1;
            else if (clr) m_flag = 1'b0;
            if (bus_wr && bus_addr == 2'd0) begin
                m_mode = bus_wdata[1:0]; m_cap = bus_wdata[2]; m_ie = bus_wdata[3];
            end
            if (bus_wr && bus_addr == 2'd1) m_dis = bus_wdata[1:0];
            m_seen = obs;
            m_c = {m_c[0], cmp_raw};
            m_p2 = m_p1; m_p1 = pin_raw;
            if (m_age < 10) m_age++;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 irq vs model", {7'd0, irq}, {7'd0, m_flag && m_ie && gie});
            chk("R9 cap_trig vs model", {7'd0, cap_trig}, {7'd0, m_cap && m_c[1]});
            chk("R13 rdata vs model", bus_rdata, m_rd);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic flag_is(input string tag, input logic exp);
        logic [7:0] v;
        rd(2'd0, v);
        chk(tag, {7'd0, v[4]}, {7'd0, exp});
    endtask

    initial begin
        logic [7:0] v;
        cyc(3);
        rst_n = 1'b1;
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
        chk("R1 cap_trig after reset", {7'd0, cap_trig}, 8'h00);
        chk("R1 rdata after reset", bus_rdata, 8'h00);
        cyc(6);
        rd(2'd0, v);
        chk("R12 R1 no false edge, level high", v, 8'h20);
        rd(2'd1, v);
        chk("R1 disable reg reset", v, 8'h00);

        // R4 toggle mode
        cmp_raw = 1'b0; cyc(5);
        flag_is("R4 falling edge in toggle", 1'b1);
        wr(2'd0, 8'h10); cyc(2);
        flag_is("R6 write-one clears", 1'b0);
        cmp_raw = 1'b1; cyc(5);
        flag_is("R4 rising edge in toggle", 1'b1);
        wr(2'd0, 8'h00); cyc(2);
        flag_is("R6 write-zero keeps", 1'b1);
        irq_ack = 1'b1; cyc(1); irq_ack = 1'b0; cyc(1);
        flag_is("R6 ack clears", 1'b0);

        // R2 rising mode
        wr(2'd0, 8'h03); cyc(3);
        cmp_raw = 1'b0; cyc(5);
        flag_is("R2 falling ignored", 1'b0);
        cmp_raw = 1'b1; cyc(5);
        flag_is("R2 rising sets", 1'b1);

        // R3 falling mode
        wr(2'd0, 8'h12); cyc(3);
        flag_is("R3 mode switch with level high", 1'b0);
        cmp_raw = 1'b0; cyc(5);
        flag_is("R3 falling sets", 1'b1);
        wr(2'd0, 8'h12); cyc(2);
        cmp_raw = 1'b1; cyc(5);
        flag_is("R3 rising ignored", 1'b0);

        // R5 reserved
        wr(2'd0, 8'h01); cyc(3);
        cmp_raw = 1'b0; cyc(5); cmp_raw = 1'b1; cyc(5);
        flag_is("R5 reserved mode quiet", 1'b0);

        // R8 request gating
        wr(2'd0, 8'h0B); cyc(3);
        cmp_raw = 1'b0; cyc(5); cmp_raw = 1'b1; cyc(5);
        chk("R8 gie low blocks irq", {7'd0, irq}, 8'h00);
        gie = 1'b1; cyc(1);
        chk("R8 irq raised", {7'd0, irq}, 8'h01);
        wr(2'd0, 8'h03); cyc(1);
        chk("R8 ie low blocks irq", {7'd0, irq}, 8'h00);
        wr(2'd0, 8'h13); cyc(2);

        // R9 capture routing
        wr(2'd0, 8'h07); cyc(1);
        chk("R9 cap follows high", {7'd0, cap_trig}, 8'h01);
        cmp_raw = 1'b0; cyc(4);
        chk("R9 cap follows low", {7'd0, cap_trig}, 8'h00);
        cmp_raw = 1'b1; cyc(4);
        wr(2'd0, 8'h13); cyc(1);
        chk("R9 cap off held low", {7'd0, cap_trig}, 8'h00);

        // R7 set beats clear in same cycle
        cmp_raw = 1'b0; cyc(5);
        cmp_raw = 1'b1; cyc(2);
        irq_ack = 1'b1;
        wr(2'd0, 8'h13);
        irq_ack = 1'b0; cyc(1);
        flag_is("R7 event wins over clear", 1'b1);
        wr(2'd0, 8'h13); cyc(2);

        // R10 spurious event on mode change
        cmp_raw = 1'b0; cyc(5);
        wr(2'd0, 8'h13); cyc(2);
        flag_is("R10 flag clear before mode change", 1'b0);
        wr(2'd0, 8'h0A); cyc(2);
        chk("R10 mode change raises irq", {7'd0, irq}, 8'h01);
        flag_is("R10 mode change sets flag", 1'b1);
        wr(2'd0, 8'h12); cyc(2);

        // R11 input disable and pin readback
        pin_raw = 2'b11; cyc(4);
        wr(2'd1, 8'hFF);
        rd(2'd1, v);
        chk("R11 reserved bits read zero", v, 8'h03);
        rd(2'd2, v);
        chk("R11 both pins forced zero", v, 8'h00);
        wr(2'd1, 8'h01);
        rd(2'd2, v);
        chk("R11 pin0 forced zero", v, 8'h02);
        wr(2'd1, 8'h00);
        rd(2'd2, v);
        chk("R11 pins visible", v, 8'h03);

        // R13 hold without read strobe
        pin_raw = 2'b00; cmp_raw = 1'b1; cyc(6);
        chk("R13 rdata held", bus_rdata, 8'h03);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule